// File: doc/BRIEF.md
# Serial Bit-Clock Source and Divisor Selector

This block derives the bit clock for one serial channel from one of three clock inputs. Each input arrives as a one-cycle tick on the system clock. The block first divides the chosen input by a fixed prescale of 16 to form a base rate, then divides that base by a programmable divisor. Small divisors run on a direct path that counts half-periods of the base rate. Larger divisors run on a programmable counter that counts whole base periods. Both paths give a bit clock of source/(16 x divisor) with an exact 50% duty cycle.

Software fills a 17-entry rate table. Entries 0 to 16 stand for the standard rates from 50 to 115200 bit/s, from slowest to fastest. Each entry holds a 2-bit source code and a divisor. A select pulse carries a rate index. The block checks the index and the entry it names against the divisor rules of that entry's source. A legal choice is queued and applied at the next terminal count, so the running clock never produces a shortened phase. An illegal choice sets a sticky error flag and leaves the running clock untouched.

A three-state machine controls the block. IDLE: no clock is produced. DIRECT: the half-period counter is running. COUNTER: the whole-period counter is running. IDLE moves to DIRECT or COUNTER as soon as a queued selection exists. DIRECT and COUNTER move to either running state when a queued selection meets a terminal count. Only reset returns the block to IDLE.

Top module: `baud_clock_select`

## Requirements
- R1: After reset `baud_lvl`, `baud_stb`, `brg_active` and `cfg_err` are 0, and `baud_lvl` does not toggle until a legal selection has been accepted.
- R2: Source code 0 takes ticks from `src_tick[0]`, code 1 from `src_tick[1]` and code 2 from `src_tick[2]`; the bit-clock period is 16 x divisor source ticks.
- R3: For source code 0, a divisor is legal when it is 1 or a non-zero even number; divisors 1, 2 and 4 run on the direct path (`brg_active`=0) and larger ones on the counter path (`brg_active`=1).
- R4: For source code 1, only divisors 1, 2 and 4 are legal, and the counter path is never used.
- R5: For source code 2, a divisor is legal only when it is even and at least 4, and the counter path is always used.
- R6: A select index of 17 or more sets `cfg_err` on the cycle after the select pulse and leaves the running period unchanged; index 16 is a valid entry.
- R7: A select naming an entry with an illegal source/divisor pair (source code 3 is always illegal) sets `cfg_err`, leaves the running clock unchanged, and `cfg_err` stays 1 until reset even after later legal selections.
- R8: In steady state `baud_lvl` is high for exactly half of each period.
- R9: A new selection made while a clock is running takes effect only at the next toggle of `baud_lvl`; the phase in progress completes at its old length and the next phase has the new length.
- R10: `baud_stb` is a single-cycle pulse asserted in the cycle in which `baud_lvl` has just risen, and only then.
- R11: A table write stores source and divisor at the written index; entries are cleared to source 0, divisor 0 by reset, and selecting a never-written entry is rejected as illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 3 | One-cycle tick per clock input, bit n for source code n |
| tbl_we | input | 1 | Rate-table write strobe |
| tbl_idx | input | 5 | Rate-table write index |
| tbl_src | input | 2 | Source code to store |
| tbl_div | input | 16 | Divisor to store |
| sel_vld | input | 1 | Rate select pulse |
| sel_idx | input | 5 | Rate index for the select pulse |
| baud_lvl | output | 1 | Divided bit clock, 50% duty |
| baud_stb | output | 1 | One-cycle pulse on each rising edge of `baud_lvl` |
| brg_active | output | 1 | 1 while the counter path drives the clock |
| cfg_err | output | 1 | Sticky flag for rejected selections |

## Verification
The bench aims at the divisors on each side of the path split. It uses divisor 4 on source 0 (direct path) against divisor 4 on source 2 (counter path), and divisor 6 on source 0. A design that picked the wrong path or the wrong reload would show a period off by a factor of two, or a wrong `brg_active`. A switch from a 384-cycle clock to a 16-cycle clock, made in the middle of a high phase, checks that the high phase still lasts 192 cycles; a design that applies the change at once would cut it short. The bench also rejects an out-of-range index, illegal pairs and never-written entries while a clock is running, and measures that the period has not moved. A design that loaded such an entry, or cleared the flag on a later legal selection, would fail there.

// File: rtl/baud_sel_pkg.sv
package baud_sel_pkg;

    typedef enum logic [1:0] {
        SRC_PIN_A = 2'd0,
        SRC_PIN_B = 2'd1,
        SRC_SYS   = 2'd2,
        SRC_NONE  = 2'd3
    } src_code_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DIRECT  = 2'd1,
        ST_COUNTER = 2'd2
    } run_state_e;

    typedef struct packed {
        logic legal;
        logic use_counter;
    } verdict_t;

    // Legality and path choice for a source/divisor pair (divisor zero-extended).
    function automatic verdict_t judge_entry(input logic [1:0] src, input logic [31:0] div);
        verdict_t v;
        v = '0;
        unique case (src)
            SRC_PIN_A: begin
                if (div == 32'd1) begin
                    v.legal = 1'b1;
                end else if (div != 32'd0 && !div[0]) begin
                    v.legal       = 1'b1;
                    v.use_counter = (div > 32'd4);
                end
            end
            SRC_PIN_B: begin
                v.legal = (div == 32'd1) || (div == 32'd2) || (div == 32'd4);
            end
            SRC_SYS: begin
                if (!div[0] && div >= 32'd4) begin
                    v.legal       = 1'b1;
                    v.use_counter = 1'b1;
                end
            end
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/baud_rate_table.sv
module baud_rate_table
    import baud_sel_pkg::*;
#(
    parameter int RATES = 17,
    parameter int IDX_W = 5,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_src,
    input  logic [DIV_W-1:0] wr_div,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_src,
    output logic [DIV_W-1:0] rd_div,
    output logic             rd_in_range,
    output logic             rd_legal,
    output logic             rd_use_counter
);

    logic [1:0]       ent_src [RATES];
    logic [DIV_W-1:0] ent_div [RATES];
    verdict_t         verdict;

    for (genvar gi = 0; gi < RATES; gi++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_src[gi] <= '0;
                ent_div[gi] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(gi)) begin
                ent_src[gi] <= wr_src;
                ent_div[gi] <= wr_div;
            end
        end
    end

    always_comb begin
        rd_src = '0;
        rd_div = '0;
        for (int i = 0; i < RATES; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_src = ent_src[i];
                rd_div = ent_div[i];
            end
        end
    end

    assign rd_in_range    = (32'(rd_idx) < 32'(RATES));
    assign verdict        = judge_entry(rd_src, 32'(rd_div));
    assign rd_legal       = rd_in_range && verdict.legal;
    assign rd_use_counter = verdict.use_counter;

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int PRESCALE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic half_step,
    output logic full_step
);

    localparam int PRE_W = $clog2(PRESCALE);
    localparam logic [PRE_W-1:0] HALF_LAST = PRE_W'(PRESCALE / 2 - 1);
    localparam logic [PRE_W-1:0] FULL_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= (phase_q == FULL_LAST) ? '0 : phase_q + PRE_W'(1);
        end
    end

    assign full_step = tick && (phase_q == FULL_LAST);
    assign half_step = tick && ((phase_q == FULL_LAST) || (phase_q == HALF_LAST));

endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic             step,
    input  logic [DIV_W-1:0] reload_val,
    output logic             terminal
);

    logic [DIV_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (step) begin
            count_q <= (count_q == '0) ? reload_val : count_q - DIV_W'(1);
        end
    end

    assign terminal = step && (count_q == '0);

endmodule

// File: rtl/baud_clock_select.sv
module baud_clock_select
    import baud_sel_pkg::*;
#(
    parameter int RATES    = 17,
    parameter int DIV_W    = 16,
    parameter int PRESCALE = 16,
    localparam int IDX_W   = $clog2(RATES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       src_tick,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic [1:0]       tbl_src,
    input  logic [DIV_W-1:0] tbl_div,
    input  logic             sel_vld,
    input  logic [IDX_W-1:0] sel_idx,
    output logic             baud_lvl,
    output logic             baud_stb,
    output logic             brg_active,
    output logic             cfg_err
);

    run_state_e       state_q, state_d;
    logic [1:0]       cur_src_q;
    logic [DIV_W-1:0] cur_div_q;
    logic             pend_vld_q;
    logic [1:0]       pend_src_q;
    logic [DIV_W-1:0] pend_div_q;
    logic             pend_ctr_q;
    logic             lvl_q, stb_q, err_q;

    logic [1:0]       rd_src;
    logic [DIV_W-1:0] rd_div;
    logic             rd_in_range, rd_legal, rd_use_counter;
    logic             act_tick, half_step, full_step, step, terminal, apply;
    logic [DIV_W-1:0] cur_reload, pend_reload;

    baud_rate_table #(
        .RATES(RATES), .IDX_W(IDX_W), .DIV_W(DIV_W)
    ) u_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (tbl_we),
        .wr_idx        (tbl_idx),
        .wr_src        (tbl_src),
        .wr_div        (tbl_div),
        .rd_idx        (sel_idx),
        .rd_src        (rd_src),
        .rd_div        (rd_div),
        .rd_in_range   (rd_in_range),
        .rd_legal      (rd_legal),
        .rd_use_counter(rd_use_counter)
    );

    always_comb begin
        unique case (cur_src_q)
            SRC_PIN_A: act_tick = src_tick[0];
            SRC_PIN_B: act_tick = src_tick[1];
            SRC_SYS:   act_tick = src_tick[2];
            default:   act_tick = 1'b0;
        endcase
    end

    baud_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (apply),
        .tick     (act_tick),
        .half_step(half_step),
        .full_step(full_step)
    );

    always_comb begin
        unique case (state_q)
            ST_DIRECT:  step = half_step;
            ST_COUNTER: step = full_step;
            default:    step = 1'b0;
        endcase
    end

    assign cur_reload  = (state_q == ST_COUNTER) ? (cur_div_q >> 1) - DIV_W'(1)
                                                 : cur_div_q - DIV_W'(1);
    assign pend_reload = pend_ctr_q ? (pend_div_q >> 1) - DIV_W'(1)
                                    : pend_div_q - DIV_W'(1);

    baud_divider #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (apply),
        .load_val  (pend_reload),
        .step      (step),
        .reload_val(cur_reload),
        .terminal  (terminal)
    );

    assign apply = pend_vld_q && ((state_q == ST_IDLE) || terminal);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DIRECT, ST_COUNTER: begin
                if (apply) state_d = pend_ctr_q ? ST_COUNTER : ST_DIRECT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Selection queue, active configuration and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld_q <= 1'b0;
            pend_src_q <= '0;
            pend_div_q <= '0;
            pend_ctr_q <= 1'b0;
            cur_src_q  <= '0;
            cur_div_q  <= '0;
            err_q      <= 1'b0;
        end else begin
            if (apply) begin
                cur_src_q  <= pend_src_q;
                cur_div_q  <= pend_div_q;
                pend_vld_q <= 1'b0;
            end
            if (sel_vld) begin
                if (rd_legal) begin
                    pend_vld_q <= 1'b1;
                    pend_src_q <= rd_src;
                    pend_div_q <= rd_div;
                    pend_ctr_q <= rd_use_counter;
                end else begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= terminal && !lvl_q;
            if (terminal) lvl_q <= ~lvl_q;
        end
    end

    assign baud_lvl   = lvl_q;
    assign baud_stb   = stb_q;
    assign brg_active = (state_q == ST_COUNTER);
    assign cfg_err    = err_q;

endmodule

// File: rtl/baud_clock_select_chk.sv
module baud_clock_select_chk
    import baud_sel_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             baud_lvl,
    input logic             baud_stb,
    input logic             brg_active,
    input logic             cfg_err,
    input run_state_e       state_q,
    input logic [1:0]       cur_src_q,
    input logic [DIV_W-1:0] cur_div_q
);

    logic running;
    assign running = (state_q != ST_IDLE);

    assert_stb_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        baud_stb |-> (baud_lvl && !$past(baud_lvl)));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!baud_lvl && !baud_stb && !brg_active));

    assert_pin_a_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cur_src_q == 2'd0) |-> (brg_active == (cur_div_q > DIV_W'(4))));

    assert_pin_b_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cur_src_q == 2'd1) |-> !brg_active);

    assert_sys_counter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cur_src_q == 2'd2) |-> brg_active);

endmodule

bind baud_clock_select baud_clock_select_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_lvl  (baud_lvl),
    .baud_stb  (baud_stb),
    .brg_active(brg_active),
    .cfg_err   (cfg_err),
    .state_q   (state_q),
    .cur_src_q (cur_src_q),
    .cur_div_q (cur_div_q)
);

// File: tb/sim_baud_clock_select.sv
module sim_baud_clock_select;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_tick = '0;
    logic        tbl_we = 1'b0;
    logic [4:0]  tbl_idx = '0;
    logic [1:0]  tbl_src = '0;
    logic [15:0] tbl_div = '0;
    logic        sel_vld = 1'b0;
    logic [4:0]  sel_idx = '0;
    logic        baud_lvl, baud_stb, brg_active, cfg_err;

    always #5 clk = ~clk;

    baud_clock_select u0 (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_src(tbl_src), .tbl_div(tbl_div),
        .sel_vld(sel_vld), .sel_idx(sel_idx),
        .baud_lvl(baud_lvl), .baud_stb(baud_stb),
        .brg_active(brg_active), .cfg_err(cfg_err)
    );

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Source ticks: source 0 every cycle, source 1 every 2nd, source 2 every 3rd
    int sc = 0;
    always @(negedge clk) begin
        sc <= sc + 1;
        src_tick[0] <= 1'b1;
        src_tick[1] <= (sc % 2 == 0);
        src_tick[2] <= (sc % 3 == 0);
    end

    // Scoreboard
    typedef struct {
        int    period;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    longint cyc = 0, edge_cyc = 0, last_rise = 0;
    longint last_high = 0, last_low = 0;
    int     rise_cnt = 0, fall_cnt = 0, stb_cnt = 0, stb_wide = 0;
    logic   prev_lvl = 1'b0, prev_stb = 1'b0;

    always @(negedge clk) begin
        exp_t item;
        cyc++;
        if (rst_n) begin
            if (baud_lvl !== prev_lvl) begin
                if (prev_lvl) last_high = cyc - edge_cyc;
                else          last_low  = cyc - edge_cyc;
                edge_cyc = cyc;
                if (baud_lvl) rise_cnt++;
                else          fall_cnt++;
            end
            if (baud_stb) begin
                stb_cnt++;
                if (prev_stb) stb_wide++;
                if (exp_q.size() > 0) begin
                    item = exp_q.pop_front();
                    check(cyc - last_rise == item.period, {item.tag, " period"},
                          cyc - last_rise, item.period);
                    check(last_high == item.period / 2, {"R8 high phase ", item.tag},
                          last_high, item.period / 2);
                end
                last_rise = cyc;
            end
        end
        prev_lvl = baud_lvl;
        prev_stb = baud_stb;
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input int idx, input int src, input int div);
        @(negedge clk);
        tbl_we  = 1'b1;
        tbl_idx = 5'(idx);
        tbl_src = 2'(src);
        tbl_div = 16'(div);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // R11: table programming
    task automatic program_table();
        wr(0, 0, 1);  wr(1, 0, 2);  wr(2, 0, 4);  wr(3, 0, 6);
        wr(4, 1, 4);  wr(5, 2, 4);  wr(6, 2, 8);  wr(7, 1, 6);
        wr(8, 2, 2);  wr(9, 0, 3);  wr(10, 1, 1); wr(11, 3, 4);
        wr(16, 2, 6);
    endtask

    task automatic select(input int idx);
        @(negedge clk);
        sel_vld = 1'b1;
        sel_idx = 5'(idx);
        @(negedge clk);
        sel_vld = 1'b0;
    endtask

    task automatic wait_rises(input int n);
        int target;
        target = rise_cnt + n;
        while (rise_cnt < target) @(posedge clk);
    endtask

    task automatic measure(input int period, input string tag);
        exp_t e;
        @(posedge clk);
        e.period = period;
        e.tag    = tag;
        exp_q.push_back(e);
        while (exp_q.size() != 0) @(posedge clk);
    endtask

    task automatic run_rate(input int idx, input int period, input bit brg, input string tag);
        select(idx);
        wait_rises(3);
        measure(period, tag);
        @(negedge clk);
        check(brg_active == brg, {tag, " path"}, brg_active, brg);
    endtask

    initial begin
        int snap;
        int target;
        do_reset();
        // R1
        check(baud_lvl == 1'b0, "R1 lvl after reset", baud_lvl, 0);
        check(baud_stb == 1'b0, "R1 stb after reset", baud_stb, 0);
        check(brg_active == 1'b0, "R1 brg after reset", brg_active, 0);
        check(cfg_err == 1'b0, "R1 err after reset", cfg_err, 0);
        snap = rise_cnt;
        repeat (100) @(negedge clk);
        check(rise_cnt == snap && baud_lvl == 1'b0, "R1 no toggle before select", rise_cnt - snap, 0);

        program_table();
        run_rate(0, 16, 1'b0, "R3 src0 div1 direct");
        run_rate(1, 32, 1'b0, "R3 src0 div2 direct");
        run_rate(2, 64, 1'b0, "R3 src0 div4 direct");
        run_rate(3, 96, 1'b1, "R3 src0 div6 counter");
        run_rate(4, 128, 1'b0, "R4 src1 div4 direct");
        run_rate(10, 32, 1'b0, "R4 src1 div1 direct");
        run_rate(5, 192, 1'b1, "R5 src2 div4 counter");
        run_rate(16, 288, 1'b1, "R6 index 16 valid, R2 src2");
        check(cfg_err == 1'b0, "R6 no error on legal selections", cfg_err, 0);

        // R9: switch mid high phase from 384 to 16 cycle period
        select(6);
        wait_rises(3);
        measure(384, "R2 src2 div8");
        wait_rises(1);
        repeat (20) @(posedge clk);
        select(0);
        target = fall_cnt + 1;
        while (fall_cnt < target) @(posedge clk);
        @(negedge clk);
        check(last_high == 192, "R9 old phase completes", last_high, 192);
        wait_rises(1);
        @(negedge clk);
        check(last_low == 8, "R9 new phase length", last_low, 8);
        wait_rises(2);
        measure(16, "R9 new period");

        // R6: out-of-range index while running
        select(17);
        check(cfg_err == 1'b1, "R6 err on index 17", cfg_err, 1);
        measure(16, "R6 clock unchanged");
        check(brg_active == 1'b0, "R6 path unchanged", brg_active, 0);

        // R11: never-written entry after reset
        do_reset();
        check(cfg_err == 1'b0, "R1 err cleared by reset", cfg_err, 0);
        program_table();
        wr(9, 0, 3);
        do_reset();
        select(2);
        check(cfg_err == 1'b1, "R11 cleared entry rejected", cfg_err, 1);
        snap = rise_cnt;
        repeat (300) @(negedge clk);
        check(rise_cnt == snap && baud_lvl == 1'b0, "R11 no clock from cleared entry", rise_cnt - snap, 0);

        // R7: illegal pairs while running
        do_reset();
        program_table();
        run_rate(0, 16, 1'b0, "R2 src0 div1 again");
        check(cfg_err == 1'b0, "R7 err clear before illegal", cfg_err, 0);
        select(7);
        check(cfg_err == 1'b1, "R7 src1 div6 rejected", cfg_err, 1);
        measure(16, "R7 clock unchanged after src1 div6");
        select(8);
        measure(16, "R7 clock unchanged after src2 div2");
        select(9);
        measure(16, "R7 clock unchanged after src0 div3");
        select(11);
        measure(16, "R7 clock unchanged after src3");
        check(brg_active == 1'b0, "R7 path unchanged", brg_active, 0);
        run_rate(3, 96, 1'b1, "R7 legal after error");
        check(cfg_err == 1'b1, "R7 err sticky", cfg_err, 1);

        // R10
        check(stb_wide == 0, "R10 strobe width", stb_wide, 0);
        check(stb_cnt == rise_cnt, "R10 strobe per rise", stb_cnt, rise_cnt);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog R1..all: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule